// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Port Model

This block is a single-clock, synthesizable stand-in for a burst SRAM with quad-data-rate behaviour. Reads and writes have their own data buses, so one read burst and one write burst can run at the same time. Each clock carries two data beats on each bus: a rising-edge lane and a falling-edge lane. One address bus is split into two lanes. The rising-edge lane feeds the read side and the falling-edge lane feeds the write side.

Every command moves four words in fixed sequential order and occupies two clocks. A new command of the same kind that arrives while a burst is still in its first clock is dropped. Write data arrives over the two clocks after the command, with active-low byte enables on each beat. Read data comes back through an output register, with a valid flag standing in for the output-enable of a tri-stated bus.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held and right after it is released, `rvalid` is 0 and both read lanes are 0. A reset during a read burst aborts that burst.
- R2: A read is requested by `rd_sel_n` low at a clock edge. The burst base is `adr_rise` with its two low bits forced to 0. Words base+0, base+1, base+2 and base+3 are delivered in that order.
- R3: For a read request sampled at edge n, words 0 and 1 sit on `rdat_rise` and `rdat_fall` after edge n+1. Words 2 and 3 sit there after edge n+2. `rvalid` is 1 for exactly those two cycles.
- R4: A read request at edge n+1, during the first clock of a running burst, is ignored, whatever address it carries. A request at edge n+2 is accepted and streams out right after the previous burst, with no idle cycle.
- R5: A write is requested by `wr_sel_n` low at edge n, and its base is `adr_fall` with the two low bits forced to 0. Words 0 and 1 are taken from `wdat_rise` and `wdat_fall` at edge n+1. Words 2 and 3 are taken the same way at edge n+2.
- R6: Byte enables are active low, one bit per byte. Bit i of `bwe_rise_n`/`bwe_fall_n` guards data bits [9i+8:9i] of its lane. A byte whose enable is 1 keeps its old content.
- R7: A write request at edge n+1, during the first clock of a running write burst, is ignored, and its address and data change no word.
- R8: Reads and writes run independently. A read word loaded at some edge includes every write beat stored at that same edge or earlier, byte by byte.
- R9: Whenever no read burst is being delivered, `rvalid` is 0 and both read lanes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_n | input | 1 | Read request, active low |
| wr_sel_n | input | 1 | Write request, active low |
| adr_rise | input | AW (6) | Address lane used for read requests |
| adr_fall | input | AW (6) | Address lane used for write requests |
| wdat_rise | input | NB*BW (18) | Write data, even beat of the clock |
| wdat_fall | input | NB*BW (18) | Write data, odd beat of the clock |
| bwe_rise_n | input | NB (2) | Byte enables for the even beat, active low |
| bwe_fall_n | input | NB (2) | Byte enables for the odd beat, active low |
| rdat_rise | output | NB*BW (18) | Read data, even beat |
| rdat_fall | output | NB*BW (18) | Read data, odd beat |
| rvalid | output | 1 | Read lanes carry burst data (bus enable) |

## Verification
A read sequencer stuck in its first half shows at the ports at once: `rvalid` stays high past two cycles, or a request that should start back-to-back output is lost. A wrong latched base, or a half-cycle bit that has slipped, returns words from the wrong group or in the wrong order, and this shows on the first beat pair after the request. A broken write path or byte merge stays hidden until that location is read back. A missing same-edge bypass shows only when a read and a write hit the same group in the same cycle, on the first beat pair.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;

  localparam int BURST_LEN = 4;

  // Word address of beat 'beat' inside the four-word group holding 'base'.
  function automatic int beat_addr(input int base, input int beat);
    return (base & ~(BURST_LEN - 1)) | (beat & (BURST_LEN - 1));
  endfunction

  // Beat index of the even lane for the given half of a burst.
  function automatic int even_beat(input logic second_half);
    return second_half ? 2 : 0;
  endfunction

endpackage

// File: rtl/qdr_burst_seq.sv
module qdr_burst_seq #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] base_i,
  output logic          act_o,
  output logic          second_o,
  output logic [AW-1:0] base_o
);

  logic accept;

  // A request is taken when idle or when the running burst is in its last clock.
  assign accept = req_i && (!act_o || second_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_o    <= 1'b0;
      second_o <= 1'b0;
      base_o   <= '0;
    end else if (accept) begin
      act_o    <= 1'b1;
      second_o <= 1'b0;
      base_o   <= base_i;
    end else if (act_o && !second_o) begin
      second_o <= 1'b1;
    end else begin
      act_o    <= 1'b0;
      second_o <= 1'b0;
    end
  end

  p_second_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && !second_o) |=> (act_o && second_o));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && !second_o) |=> (base_o == $past(base_o)));

  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (act_o && !second_o));

  p_no_half_without_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    second_o |-> act_o);

endmodule

// File: rtl/qdr_burst_store.sv
module qdr_burst_store #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa0,
  input  logic [AW-1:0] wa1,
  input  logic [NB*BW-1:0] wd0,
  input  logic [NB*BW-1:0] wd1,
  input  logic [NB-1:0] wm0,
  input  logic [NB-1:0] wm1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [NB*BW-1:0] rd0,
  output logic [NB*BW-1:0] rd1
);

  localparam int W     = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ra [2];
  logic [W-1:0]  rd [2];

  assign ra[0] = ra0;
  assign ra[1] = ra1;
  assign rd0   = rd[0];
  assign rd1   = rd[1];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (wm0[b]) mem[wa0][b*BW +: BW] <= wd0[b*BW +: BW];
        if (wm1[b]) mem[wa1][b*BW +: BW] <= wd1[b*BW +: BW];
      end
    end
  end

  // Read ports see the stored word, overlaid byte-wise by beats stored at this edge.
  for (genvar p = 0; p < 2; p++) begin : g_port
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic hit0, hit1;
      assign hit0 = we && (wa0 == ra[p]) && wm0[b];
      assign hit1 = we && (wa1 == ra[p]) && wm1[b];
      assign rd[p][b*BW +: BW] = hit0 ? wd0[b*BW +: BW] :
                                 hit1 ? wd1[b*BW +: BW] :
                                        mem[ra[p]][b*BW +: BW];
    end
  end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    adr_rise,
  input  logic [AW-1:0]    adr_fall,
  input  logic [NB*BW-1:0] wdat_rise,
  input  logic [NB*BW-1:0] wdat_fall,
  input  logic [NB-1:0]    bwe_rise_n,
  input  logic [NB-1:0]    bwe_fall_n,
  output logic [NB*BW-1:0] rdat_rise,
  output logic [NB*BW-1:0] rdat_fall,
  output logic             rvalid
);

  import qdr_burst_pkg::*;

  localparam int W = NB * BW;

  logic          rd_act, rd_second, wr_act, wr_second;
  logic [AW-1:0] rd_base, wr_base;
  logic [AW-1:0] rd_a0, rd_a1, wr_a0, wr_a1;
  logic [W-1:0]  rd_w0, rd_w1;

  qdr_burst_seq #(.AW(AW)) u_rd_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (!rd_sel_n),
    .base_i   (adr_rise),
    .act_o    (rd_act),
    .second_o (rd_second),
    .base_o   (rd_base)
  );

  qdr_burst_seq #(.AW(AW)) u_wr_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (!wr_sel_n),
    .base_i   (adr_fall),
    .act_o    (wr_act),
    .second_o (wr_second),
    .base_o   (wr_base)
  );

  assign rd_a0 = AW'(beat_addr(int'(rd_base), even_beat(rd_second)));
  assign rd_a1 = AW'(beat_addr(int'(rd_base), even_beat(rd_second) + 1));
  assign wr_a0 = AW'(beat_addr(int'(wr_base), even_beat(wr_second)));
  assign wr_a1 = AW'(beat_addr(int'(wr_base), even_beat(wr_second) + 1));

  qdr_burst_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
    .clk (clk),
    .we  (wr_act),
    .wa0 (wr_a0),
    .wa1 (wr_a1),
    .wd0 (wdat_rise),
    .wd1 (wdat_fall),
    .wm0 (~bwe_rise_n),
    .wm1 (~bwe_fall_n),
    .ra0 (rd_a0),
    .ra1 (rd_a1),
    .rd0 (rd_w0),
    .rd1 (rd_w1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      rdat_rise <= '0;
      rdat_fall <= '0;
    end else if (rd_act) begin
      rvalid    <= 1'b1;
      rdat_rise <= rd_w0;
      rdat_fall <= rd_w1;
    end else begin
      rvalid    <= 1'b0;
      rdat_rise <= '0;
      rdat_fall <= '0;
    end
  end

  p_valid_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> rvalid);

  p_valid_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid);

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdat_rise == '0 && rdat_fall == '0));

  p_write_two_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_act) |=> wr_act);

  p_lanes_differ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> (wr_a0 != wr_a1));

endmodule

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int W  = NB * BW;
  localparam int DEPTH = 1 << AW;

  // {base address, byte-enable mask for beats 3..0 (2 bits each, active low)}
  localparam logic [13:0] VEC [6] = '{
    {6'd5,  8'b00_00_00_00},
    {6'd22, 8'b01_10_00_11},
    {6'd63, 8'b11_11_11_11},
    {6'd36, 8'b10_01_10_01},
    {6'd9,  8'b00_11_00_11},
    {6'd50, 8'b01_01_10_10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] adr_rise = '0, adr_fall = '0;
  logic [W-1:0]  wdat_rise = '0, wdat_fall = '0;
  logic [NB-1:0] bwe_rise_n = '1, bwe_fall_n = '1;
  logic [W-1:0]  rdat_rise, rdat_fall;
  logic          rvalid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] refm [DEPTH];

  always #2 clk = ~clk;

  qdr_burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u_qdr_burst_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .adr_rise(adr_rise), .adr_fall(adr_fall),
    .wdat_rise(wdat_rise), .wdat_fall(wdat_fall),
    .bwe_rise_n(bwe_rise_n), .bwe_fall_n(bwe_fall_n),
    .rdat_rise(rdat_rise), .rdat_fall(rdat_fall), .rvalid(rvalid)
  );

  function automatic logic [W-1:0] pat(input int seed, input int beat);
    return W'(seed * 9973 + beat * 1237 + 5);
  endfunction

  function automatic int word_of(input int base, input int beat);
    return (base / 4) * 4 + beat;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_put(input int addr, input logic [W-1:0] d, input logic [NB-1:0] m_n);
    for (int b = 0; b < NB; b++)
      if (!m_n[b]) refm[addr][b*BW +: BW] = d[b*BW +: BW];
  endtask

  task automatic drive_beats(input int base, input int seed, input int half, input logic [7:0] m);
    wdat_rise  = pat(seed, 2*half);
    wdat_fall  = pat(seed, 2*half + 1);
    bwe_rise_n = m[4*half +: 2];
    bwe_fall_n = m[4*half + 2 +: 2];
    ref_put(word_of(base, 2*half), wdat_rise, bwe_rise_n);
    ref_put(word_of(base, 2*half + 1), wdat_fall, bwe_fall_n);
  endtask

  task automatic write_burst(input int base, input int seed, input logic [7:0] m);
    wr_sel_n = 1'b0; adr_fall = AW'(base);
    tick();
    wr_sel_n = 1'b1;
    drive_beats(base, seed, 0, m);
    tick();
    drive_beats(base, seed, 1, m);
    tick();
    bwe_rise_n = '1; bwe_fall_n = '1;
  endtask

  task automatic check_pair(input string tag, input int base, input int half);
    chk({tag, " valid"}, W'(rvalid), W'(1));
    chk({tag, " even"}, rdat_rise, refm[word_of(base, 2*half)]);
    chk({tag, " odd"}, rdat_fall, refm[word_of(base, 2*half + 1)]);
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " idle valid"}, W'(rvalid), W'(0));
    chk({tag, " idle even"}, rdat_rise, '0);
    chk({tag, " idle odd"}, rdat_fall, '0);
  endtask

  task automatic read_check(input string tag, input int base);
    rd_sel_n = 1'b0; adr_rise = AW'(base);
    tick();
    rd_sel_n = 1'b1;
    tick();
    check_pair(tag, base, 0);
    tick();
    check_pair(tag, base, 1);
    tick();
    check_idle({tag, " R9"});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk); tick(); tick();
    check_idle("R1 in reset");
    rst_n = 1'b1;
    tick();
    check_idle("R1 after release");

    // Fill storage with known content (R5, unmasked)
    for (int g = 0; g < DEPTH / 4; g++) write_burst(g * 4, g + 1, 8'h00);

    // Vector table: masked writes then read back (R2, R3, R5, R6)
    for (int i = 0; i < 6; i++) begin
      write_burst(int'(VEC[i][13:8]), 100 + i, VEC[i][7:0]);
      read_check($sformatf("R2 R6 vec%0d", i), int'(VEC[i][13:8]));
    end

    // R4: request during first clock of a burst is ignored
    rd_sel_n = 1'b0; adr_rise = 6'd8;
    tick();
    adr_rise = 6'd40;
    tick();
    check_pair("R4 ignore first", 8, 0);
    rd_sel_n = 1'b1;
    tick();
    check_pair("R4 ignore second", 8, 1);
    tick();
    check_idle("R4 ignore end");

    // R4: back-to-back bursts
    rd_sel_n = 1'b0; adr_rise = 6'd13;
    tick();
    rd_sel_n = 1'b1;
    tick();
    check_pair("R4 b2b A0", 12, 0);
    rd_sel_n = 1'b0; adr_rise = 6'd20;
    tick();
    check_pair("R4 b2b A1", 12, 1);
    rd_sel_n = 1'b1;
    tick();
    check_pair("R4 b2b B0", 20, 0);
    tick();
    check_pair("R4 b2b B1", 20, 1);
    tick();
    check_idle("R4 b2b end");

    // R7: write request during first clock of a write burst is ignored
    wr_sel_n = 1'b0; adr_fall = 6'd24;
    tick();
    adr_fall = 6'd28;
    drive_beats(24, 200, 0, 8'h00);
    tick();
    wr_sel_n = 1'b1;
    drive_beats(24, 200, 1, 8'h00);
    tick();
    tick();
    read_check("R7 untouched", 28);
    read_check("R7 written", 24);

    // R8: read and write of the same group issued at the same edge
    wr_sel_n = 1'b0; adr_fall = 6'd32;
    rd_sel_n = 1'b0; adr_rise = 6'd34;
    tick();
    wr_sel_n = 1'b1; rd_sel_n = 1'b1;
    drive_beats(32, 300, 0, 8'b00_00_00_00);
    tick();
    check_pair("R8 fwd first", 32, 0);
    drive_beats(32, 301, 1, 8'b10_01_00_00);
    tick();
    check_pair("R8 fwd merged", 32, 1);
    bwe_rise_n = '1; bwe_fall_n = '1;
    tick();
    check_idle("R8 end");

    // R8: concurrent read and write of different groups
    wr_sel_n = 1'b0; adr_fall = 6'd48;
    rd_sel_n = 1'b0; adr_rise = 6'd44;
    tick();
    wr_sel_n = 1'b1; rd_sel_n = 1'b1;
    drive_beats(48, 400, 0, 8'h00);
    tick();
    check_pair("R8 indep first", 44, 0);
    drive_beats(48, 400, 1, 8'h00);
    tick();
    check_pair("R8 indep second", 44, 1);
    tick();
    read_check("R8 indep write", 48);

    // R1: reset during a read burst
    rd_sel_n = 1'b0; adr_rise = 6'd4;
    tick();
    rd_sel_n = 1'b1; rst_n = 1'b0;
    tick();
    check_idle("R1 mid-burst reset");
    rst_n = 1'b1;
    tick();
    check_idle("R1 after mid-burst");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule